// File: doc/BRIEF.md
# UART FIFO DMA Request Generator

This block drives the two active-low DMA request lines of a UART that has receive and transmit FIFOs. A receive request asks the DMA engine to drain received characters. A transmit request asks it to supply characters to send. The block does not hold the FIFOs. It watches their fill counts, together with the receiver's trigger and timeout flags, and derives each request from them.

Two control bits select the signalling scheme. One bit turns the FIFOs on and the other selects the DMA style. In single-transfer style, each request simply reflects whether there is work to do. In multi-transfer style, each request is armed by a start condition and held until the FIFO reaches its far end: the receive FIFO empty, or the transmit FIFO full. This lets the DMA engine issue bursts. When the FIFOs are off, only the single-transfer style can be used.

Top module: `uart_dma_req`

## Requirements
- R1: Multi-transfer style applies only when `fifo_en_i`=1 and `dma_mode_i`=1. With `fifo_en_i`=0, single-transfer style applies whatever `dma_mode_i` is.
- R2: Both `rx_req_no` and `tx_req_no` are high while `rst_ni` is low, and stay high until the first rising clock edge after reset is released.
- R3: In single-transfer style, `rx_req_no` is low exactly when `rx_count_i` is nonzero.
- R4: In multi-transfer style, an idle receive request goes low only when `rx_count_i` is nonzero and either `rx_trig_i` or `rx_timeout_i` is 1. Data below the trigger level, with no timeout, leaves it high.
- R5: In multi-transfer style, an active receive request stays low while `rx_count_i` is nonzero, even after the trigger and timeout flags drop. It goes high when the count reaches 0, and it needs a new trigger or timeout to assert again.
- R6: In single-transfer style, `tx_req_no` is low exactly when `tx_count_i` is 0.
- R7: In multi-transfer style, `tx_req_no` goes low when `tx_count_i` is 0 and stays low until `tx_count_i` equals DEPTH. It then stays high at any partial fill until the count returns to 0.
- R8: A change of the mode bits changes the outputs in the same cycle. A held request state does not survive a cycle spent in single-transfer style.
- R9: A receive timeout, or a trigger flag, while `rx_count_i` is 0 does not assert `rx_req_no`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | FIFO enable control bit |
| dma_mode_i | input | 1 | DMA style bit (1 = multi-transfer) |
| rx_count_i | input | CNT_W | Characters held in the receive FIFO or holding register |
| rx_trig_i | input | 1 | Receive trigger level reached |
| rx_timeout_i | input | 1 | Receive character timeout pending |
| tx_count_i | input | CNT_W | Characters held in the transmit FIFO or holding register |
| rx_req_no | output | 1 | Receive DMA request, active low |
| tx_req_no | output | 1 | Transmit DMA request, active low |

## Verification
The only internal state is one held-request flag per direction. If that flag is wrong, a multi-transfer request drops partway through a drain or fill, or it stays asserted across an empty or full boundary. Either fault shows on the request pin in the first cycle the stale flag is used, which is the cycle after the count step that should have changed it. The sequences therefore walk each count through its endpoints and through partial values that come after an endpoint. They also switch modes in the middle of a held request.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;
  typedef enum logic {
    XFER_SINGLE = 1'b0,
    XFER_MULTI  = 1'b1
  } xfer_mode_e;
endpackage

// File: rtl/dma_mode_dec.sv
module dma_mode_dec
  import dma_req_pkg::*;
(
  input  logic       fifo_en_i,
  input  logic       dma_mode_i,
  output xfer_mode_e mode_o
);
  // FIFOs off forces single-transfer style
  always_comb begin
    if (fifo_en_i && dma_mode_i) mode_o = XFER_MULTI;
    else                         mode_o = XFER_SINGLE;
  end
endmodule

// File: rtl/dma_rx_req.sv
module dma_rx_req #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             multi_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             trig_i,
  input  logic             timeout_i,
  output logic             active_o
);
  logic armed_q;
  logic has_data;

  assign has_data = (count_i != '0);

  always_comb begin
    if (multi_i) active_o = has_data && (armed_q || trig_i || timeout_i);
    else         active_o = has_data;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= run_i && multi_i && active_o;
  end

  // R5
  rx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && multi_i && $past(multi_i) && $past(active_o) && has_data)
    |-> active_o);

  // R4
  rx_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && multi_i && $past(multi_i) && !$past(active_o) && active_o)
    |-> (trig_i || timeout_i));

  // R9
  rx_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_i == '0) |-> !active_o);
endmodule

// File: rtl/dma_tx_req.sv
module dma_tx_req #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             multi_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             active_o
);
  logic armed_q;
  logic empty;
  logic full;

  assign empty = (count_i == '0);
  assign full  = (count_i >= CNT_W'(DEPTH));

  always_comb begin
    if (multi_i) active_o = empty || (armed_q && !full);
    else         active_o = empty;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= run_i && multi_i && active_o && !full;
  end

  // R7
  tx_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && multi_i && $past(multi_i) && $past(active_o) && !full)
    |-> active_o);

  // R7
  tx_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (multi_i && full) |-> !active_o);

  // R6
  tx_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty |-> active_o);
endmodule

// File: rtl/uart_dma_req.sv
module uart_dma_req
  import dma_req_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_en_i,
  input  logic             dma_mode_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic             rx_trig_i,
  input  logic             rx_timeout_i,
  input  logic [CNT_W-1:0] tx_count_i,
  output logic             rx_req_no,
  output logic             tx_req_no
);
  xfer_mode_e mode;
  logic       multi;
  logic       run_q;
  logic       rx_act;
  logic       tx_act;

  dma_mode_dec u_dec (
    .fifo_en_i (fifo_en_i),
    .dma_mode_i(dma_mode_i),
    .mode_o    (mode)
  );

  assign multi = (mode == XFER_MULTI);

  // requests held off until first edge after reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= 1'b1;
  end

  dma_rx_req #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_q),
    .multi_i  (multi),
    .count_i  (rx_count_i),
    .trig_i   (rx_trig_i),
    .timeout_i(rx_timeout_i),
    .active_o (rx_act)
  );

  dma_tx_req #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_q),
    .multi_i (multi),
    .count_i (tx_count_i),
    .active_o(tx_act)
  );

  assign rx_req_no = !(run_q && rx_act);
  assign tx_req_no = !(run_q && tx_act);

  // R1
  single_no_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !fifo_en_i) |-> (rx_req_no == (rx_count_i == '0)));
endmodule

// File: tb/sim_uart_dma_req.sv
module sim_uart_dma_req;
  localparam int unsigned DEPTH = 16;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  typedef struct {
    logic  rx_n;
    logic  tx_n;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic fifo_en = 1'b0, dma_mode = 1'b0, rx_trig = 1'b0, rx_to = 1'b0;
  logic [CNT_W-1:0] rx_cnt = '0, tx_cnt = '0;
  logic rx_req_n, tx_req_n;
  exp_t sb[$];
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  uart_dma_req #(.DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .fifo_en_i(fifo_en), .dma_mode_i(dma_mode),
    .rx_count_i(rx_cnt), .rx_trig_i(rx_trig), .rx_timeout_i(rx_to),
    .tx_count_i(tx_cnt), .rx_req_no(rx_req_n), .tx_req_no(tx_req_n)
  );

  task automatic cmp(string tag, logic arx, logic atx, logic erx, logic etx);
    checks++;
    if (arx !== erx || atx !== etx) begin
      errors++;
      $display("FAIL %s rx_req_no=%b tx_req_no=%b expected %b %b", tag, arx, atx, erx, etx);
    end
  endtask

  task automatic step(logic fe, logic dm, int rc, logic tg, logic to, int tc,
                      logic erx, logic etx, string tag);
    exp_t e;
    @(posedge clk);
    #1;
    fifo_en = fe; dma_mode = dm; rx_cnt = CNT_W'(rc); rx_trig = tg; rx_to = to;
    tx_cnt = CNT_W'(tc);
    e.rx_n = erx; e.tx_n = etx; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: compares mid-cycle, after inputs settle and before next edge
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        cmp(e.tag, rx_req_n, tx_req_n, e.rx_n, e.tx_n);
      end
    end
  end

  initial begin
    rx_cnt = CNT_W'(3);
    #1;
    cmp("R2 in reset", rx_req_n, tx_req_n, 1'b1, 1'b1);
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(negedge clk);
    cmp("R2 before first edge", rx_req_n, tx_req_n, 1'b1, 1'b1);
    // single style, FIFOs off with dma bit set
    step(0, 1, 0, 0, 0, 0, 1, 0, "R1 R3 R6 empty");
    step(0, 1, 1, 0, 0, 1, 0, 1, "R3 R6 one char");
    step(1, 0, 5, 0, 0, 5, 0, 1, "R3 R6 fifo single");
    step(1, 0, 0, 0, 0, 0, 1, 0, "R3 R6 drained");
    // multi style
    step(1, 1, 3, 0, 0, 0, 1, 0, "R4 below trigger");
    step(1, 1, 8, 1, 0, 4, 0, 0, "R4 trigger R7 fill");
    step(1, 1, 6, 0, 0, 15, 0, 0, "R5 hold R7 near full");
    step(1, 1, 1, 0, 0, 16, 0, 1, "R5 hold R7 full");
    step(1, 1, 0, 0, 0, 10, 1, 1, "R5 empty R7 partial");
    step(1, 1, 2, 0, 0, 3, 1, 1, "R5 no rearm R7 partial");
    step(1, 1, 0, 0, 1, 0, 1, 0, "R9 timeout empty R7 empty");
    step(1, 1, 2, 0, 1, 0, 0, 0, "R4 timeout");
    step(1, 1, 2, 0, 0, 1, 0, 0, "R5 hold R7 hold");
    step(1, 0, 2, 0, 0, 1, 0, 1, "R8 to single");
    step(1, 1, 2, 0, 0, 1, 1, 1, "R8 hold dropped");
    step(0, 1, 2, 1, 0, 0, 0, 0, "R1 fifo off");
    step(0, 1, 0, 1, 1, 0, 1, 0, "R9 R1 flags no data");
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule